// File: doc/BRIEF.md
# FIFO-to-ACIA Bus Bridge with Bootstrap

This block sits on the processor side of a small single-board machine. It makes a parallel USB receive/transmit FIFO look like a minimal serial adapter on the I/O bus. A byte window of eight port addresses is decoded twice: once at the base 0x80 and once at the mirror 0xA0. Inside that window, the processor finds a status port and a data port. Reading the data port while no byte is waiting stretches the bus cycle with an active-low wait line until the FIFO delivers one. Writing the data port never stretches the cycle. The block also provides a load strobe for an external RAM page register. There is no control register and no interrupt output.

After reset the block is in bootstrap mode. In this mode every read cycle the processor makes, whether a memory read, an opcode fetch or an I/O read, is answered with the next FIFO byte. Writes still go to memory and ports as usual. A host can therefore stream a short loader program into memory through the FIFO. The loader leaves bootstrap mode by touching the bootstrap-exit port, or the mode ends with an interrupt-acknowledge cycle.

All bus strobes are sampled on the block clock, which runs several times faster than the processor bus. A bus cycle is recognised on the first clock at which its strobe is seen active.

Top module: `fifo_acia_bridge`

## Requirements
- R1: The window responds only where address bits 7..3 equal 10000b (0x80..0x87) or 10100b (0xA0..0xA7). Every other port address, including the rest of 0x80..0xBF, is neither driven on reads nor acted on for writes. Inside the window, offset 0 is status, offset 1 is data, offset 2 is the page register, and offset 3 is bootstrap exit.
- R2: Outside bootstrap mode, an I/O read of offset 0 drives cpu_dout_oe high. The returned byte has bit 0 equal to the inverse of fifo_rxf_n, bit 1 equal to the inverse of fifo_txe_n, and bits 7..2 equal to 0.
- R3: A data-port read while a byte is waiting gives a one-clock low pulse on fifo_rd_n. The byte the FIFO presents during that pulse then appears on cpu_dout with cpu_dout_oe high until the read strobe is released.
- R4: A data-port read while fifo_rxf_n is high holds cpu_wait_n low for as long as fifo_rxf_n stays high. Once a byte arrives, cpu_wait_n returns high and the read completes with that byte. cpu_wait_n is low only during a read cycle routed to the FIFO.
- R5: An I/O write to offset 1 gives exactly one clock of fifo_wr_n low, with the written byte on fifo_dout. cpu_wait_n stays high during the write whatever fifo_txe_n shows.
- R6: A write to offset 0 (control) or to offsets 4..7 causes no FIFO write and no page load. A read of offsets 2..7 does not drive cpu_dout_oe.
- R7: Reset sets bootstrap mode. While it is set, every memory read, opcode fetch and I/O read at any address returns the next FIFO byte, in FIFO order.
- R8: In bootstrap mode, memory writes produce no FIFO write, and I/O writes behave exactly as outside bootstrap mode.
- R9: Bootstrap mode is cleared by an I/O read or write of offset 3 in either copy of the window, or by an interrupt-acknowledge cycle (cpu_m1_n and cpu_iord_n both low). The mode stays clear until reset. A read of offset 3 made while in bootstrap mode is itself still served from the FIFO. After the mode is cleared, memory reads no longer touch the FIFO.
- R10: An I/O write to offset 2 in either window copy gives a one-clock high pulse on page_we, with the written byte on page_data.
- R11: Each accepted FIFO-routed read cycle consumes exactly one byte: exactly one fifo_rd_n pulse, however long the processor holds its read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the processor bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | Low byte of the processor address bus |
| cpu_din | input | 8 | Processor data bus, write direction |
| cpu_iord_n | input | 1 | Active-low I/O read strobe |
| cpu_iowr_n | input | 1 | Active-low I/O write strobe |
| cpu_mreq_n | input | 1 | Active-low memory request |
| cpu_rd_n | input | 1 | Active-low read |
| cpu_wr_n | input | 1 | Active-low write |
| cpu_m1_n | input | 1 | Active-low first-machine-cycle marker |
| cpu_dout | output | 8 | Data returned to the processor |
| cpu_dout_oe | output | 1 | Drive enable for cpu_dout |
| cpu_wait_n | output | 1 | Active-low bus wait |
| fifo_din | input | 8 | Byte presented by the FIFO |
| fifo_rxf_n | input | 1 | Low when the FIFO holds a received byte (pulled high when floating) |
| fifo_txe_n | input | 1 | Low when the FIFO can accept a byte (pulled high when floating) |
| fifo_rd_n | output | 1 | Active-low FIFO read strobe |
| fifo_wr_n | output | 1 | Active-low FIFO write strobe |
| fifo_dout | output | 8 | Byte written to the FIFO |
| page_we | output | 1 | One-clock load pulse for the RAM page register |
| page_data | output | 8 | Value for the RAM page register |

## Verification
The assertions assume that the processor holds each strobe steady for several block clocks. They also assume that at most one kind of bus cycle (memory read, memory write, I/O read, I/O write, interrupt acknowledge) is active at a time, and that a read strobe is never released while cpu_wait_n is low. The FIFO flags are assumed to be settled at every sampling edge. The stimulus respects these assumptions: all inputs change on the falling clock edge, every cycle is held until the bridge has finished with it, and two idle clocks separate consecutive cycles. The FIFO model in the bench only changes its flags and data between clock edges.

// File: rtl/acia_bridge_pkg.sv
package acia_bridge_pkg;

   // Offsets inside the decoded port window (behaviour depends on them)
   localparam int unsigned OFS_STATUS   = 0;
   localparam int unsigned OFS_DATA     = 1;
   localparam int unsigned OFS_PAGE     = 2;
   localparam int unsigned OFS_BOOT_OFF = 3;

   // Status bit positions
   localparam int unsigned ST_RX_READY = 0;
   localparam int unsigned ST_TX_EMPTY = 1;

   // Phases of a FIFO-routed read
   typedef enum logic [1:0] {
      RD_IDLE  = 2'd0,
      RD_STALL = 2'd1,
      RD_FETCH = 2'd2,
      RD_HOLD  = 2'd3
   } rd_phase_t;

endpackage

// File: rtl/acia_flag_sync.sv
module acia_flag_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] flag_in,
   output logic [WIDTH-1:0] flag_out
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("acia_flag_sync: WIDTH must be at least 1");
      end

      if (STAGES == 0) begin : g_pass
         assign flag_out = flag_in;
      end else begin : g_chain
         // reset value is all ones: an inactive-low flag means "not ready"
         logic [WIDTH-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stage_q[s] <= '1;
               end else if (s == 0) begin
                  stage_q[s] <= flag_in;
               end else begin
                  stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign flag_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/acia_bus_decode.sv
module acia_bus_decode #(
   parameter int unsigned          ADDR_W    = 8,
   parameter int unsigned          WIN_BITS  = 3,
   parameter logic [ADDR_W-1:0]    WIN_A     = 8'h80,
   parameter logic [ADDR_W-1:0]    WIN_B     = 8'hA0,
   parameter bit                   MIRROR_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                iord_n,
   input  logic                iowr_n,
   input  logic                mreq_n,
   input  logic                rd_n,
   input  logic                wr_n,
   input  logic                m1_n,
   output logic                any_rd,
   output logic                io_rd,
   output logic                rd_start,
   output logic                wr_start,
   output logic                ack_start,
   output logic                mem_wr,
   output logic                win_hit,
   output logic [WIN_BITS-1:0] offset
);

   localparam int unsigned TAG_W = ADDR_W - WIN_BITS;

   generate
      if (WIN_BITS < 2) begin : g_bad_win
         $error("acia_bus_decode: window needs at least four offsets");
      end
      if (ADDR_W <= WIN_BITS) begin : g_bad_addr
         $error("acia_bus_decode: ADDR_W must exceed WIN_BITS");
      end
      if (WIN_A[WIN_BITS-1:0] != '0) begin : g_bad_base_a
         $error("acia_bus_decode: WIN_A not aligned to the window size");
      end
      if (MIRROR_EN && (WIN_B[WIN_BITS-1:0] != '0)) begin : g_bad_base_b
         $error("acia_bus_decode: WIN_B not aligned to the window size");
      end
   endgenerate

   logic [TAG_W-1:0] tag;
   logic             hit_a;
   logic             hit_b;

   assign tag    = addr[ADDR_W-1:WIN_BITS];
   assign offset = addr[WIN_BITS-1:0];
   assign hit_a  = (tag == WIN_A[ADDR_W-1:WIN_BITS]);

   generate
      if (MIRROR_EN) begin : g_mirror
         assign hit_b = (tag == WIN_B[ADDR_W-1:WIN_BITS]);
      end else begin : g_single
         assign hit_b = 1'b0;
      end
   endgenerate

   assign win_hit = hit_a | hit_b;

   logic mem_rd;
   logic io_wr;
   logic ack;

   assign io_rd  = ~iord_n & m1_n;
   assign mem_rd = ~mreq_n & ~rd_n;
   assign any_rd = io_rd | mem_rd;
   assign io_wr  = ~iowr_n;
   assign ack    = ~iord_n & ~m1_n;
   assign mem_wr = ~mreq_n & ~wr_n;

   logic rd_seen_q;
   logic wr_seen_q;
   logic ack_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_seen_q  <= 1'b0;
         wr_seen_q  <= 1'b0;
         ack_seen_q <= 1'b0;
      end else begin
         rd_seen_q  <= any_rd;
         wr_seen_q  <= io_wr;
         ack_seen_q <= ack;
      end
   end

   assign rd_start  = any_rd & ~rd_seen_q;
   assign wr_start  = io_wr & ~wr_seen_q;
   assign ack_start = ack & ~ack_seen_q;

   // R11
   rd_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |=> !rd_start);

   // R5
   wr_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> !wr_start);

endmodule

// File: rtl/acia_rd_engine.sv
module acia_rd_engine
   import acia_bridge_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_start,
   input  logic              any_rd,
   input  logic              need_fifo,
   input  logic              rx_avail,
   input  logic [DATA_W-1:0] fifo_din,
   output logic              busy,
   output logic              hold,
   output logic [DATA_W-1:0] byte_q,
   output logic              fifo_rd_n,
   output logic              wait_n
);

   rd_phase_t phase_q;
   rd_phase_t phase_nx;

   always_comb begin
      phase_nx = phase_q;
      unique case (phase_q)
         RD_IDLE: begin
            if (rd_start && need_fifo) begin
               phase_nx = rx_avail ? RD_FETCH : RD_STALL;
            end
         end
         RD_STALL: begin
            if (!any_rd) begin
               phase_nx = RD_IDLE;
            end else if (rx_avail) begin
               phase_nx = RD_FETCH;
            end
         end
         RD_FETCH: phase_nx = RD_HOLD;
         RD_HOLD: begin
            if (!any_rd) begin
               phase_nx = RD_IDLE;
            end
         end
         default: phase_nx = RD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= RD_IDLE;
         byte_q  <= '0;
      end else begin
         phase_q <= phase_nx;
         if (phase_q == RD_FETCH) begin
            byte_q <= fifo_din;
         end
      end
   end

   assign busy      = (phase_q != RD_IDLE);
   assign hold      = (phase_q == RD_HOLD);
   assign fifo_rd_n = ~(phase_q == RD_FETCH);
   assign wait_n    = ~(((phase_q == RD_IDLE) && rd_start && need_fifo) ||
                        (phase_q == RD_STALL) || (phase_q == RD_FETCH));

   // R11
   rd_pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_rd_n |=> fifo_rd_n);

   // R4
   wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wait_n) && any_rd) |-> $past(!fifo_rd_n));

   // R3
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && $past(hold)) |-> $stable(byte_q));

endmodule

// File: rtl/acia_wr_ctl.sv
module acia_wr_ctl
   import acia_bridge_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned WIN_BITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_start,
   input  logic                rd_start,
   input  logic                io_rd,
   input  logic                ack_start,
   input  logic                win_hit,
   input  logic [WIN_BITS-1:0] offset,
   input  logic [DATA_W-1:0]   din,
   output logic                fifo_wr_n,
   output logic [DATA_W-1:0]   fifo_dout,
   output logic                page_we,
   output logic [DATA_W-1:0]   page_data,
   output logic                boot
);

   logic at_data;
   logic at_page;
   logic at_exit;
   logic boot_clear;

   assign at_data = win_hit && (offset == WIN_BITS'(OFS_DATA));
   assign at_page = win_hit && (offset == WIN_BITS'(OFS_PAGE));
   assign at_exit = win_hit && (offset == WIN_BITS'(OFS_BOOT_OFF));

   assign boot_clear = ack_start || (at_exit && (wr_start || (rd_start && io_rd)));

   logic tx_pulse_q;
   logic pg_pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_pulse_q <= 1'b0;
         pg_pulse_q <= 1'b0;
         fifo_dout  <= '0;
         page_data  <= '0;
         boot       <= 1'b1;
      end else begin
         tx_pulse_q <= wr_start && at_data;
         pg_pulse_q <= wr_start && at_page;
         if (wr_start && at_data) begin
            fifo_dout <= din;
         end
         if (wr_start && at_page) begin
            page_data <= din;
         end
         if (boot_clear) begin
            boot <= 1'b0;
         end
      end
   end

   assign fifo_wr_n = ~tx_pulse_q;
   assign page_we   = pg_pulse_q;

   // R5
   wr_pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_wr_n |=> fifo_wr_n);

   // R10
   page_pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_we |=> !page_we);

   // R9
   boot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !boot |=> !boot);

endmodule

// File: rtl/fifo_acia_bridge.sv
module fifo_acia_bridge
   import acia_bridge_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 8,
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       WIN_BITS   = 3,
   parameter logic [ADDR_W-1:0] WIN_A      = 8'h80,
   parameter logic [ADDR_W-1:0] WIN_B      = 8'hA0,
   parameter bit                MIRROR_EN  = 1'b1,
   parameter int unsigned       FLAG_SYNC  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_din,
   input  logic              cpu_iord_n,
   input  logic              cpu_iowr_n,
   input  logic              cpu_mreq_n,
   input  logic              cpu_rd_n,
   input  logic              cpu_wr_n,
   input  logic              cpu_m1_n,
   output logic [DATA_W-1:0] cpu_dout,
   output logic              cpu_dout_oe,
   output logic              cpu_wait_n,
   input  logic [DATA_W-1:0] fifo_din,
   input  logic              fifo_rxf_n,
   input  logic              fifo_txe_n,
   output logic              fifo_rd_n,
   output logic              fifo_wr_n,
   output logic [DATA_W-1:0] fifo_dout,
   output logic              page_we,
   output logic [DATA_W-1:0] page_data
);

   localparam int unsigned PAD_W = DATA_W - 2;

   generate
      if (DATA_W < 3) begin : g_bad_data
         $error("fifo_acia_bridge: DATA_W too narrow for the status byte");
      end
   endgenerate

   // ---------------- flag conditioning ----------------
   logic [1:0] flags_s;

   acia_flag_sync #(
      .WIDTH  (2),
      .STAGES (FLAG_SYNC)
   ) i_flag_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .flag_in  ({fifo_txe_n, fifo_rxf_n}),
      .flag_out (flags_s)
   );

   logic rx_avail;
   logic tx_room;
   assign rx_avail = ~flags_s[0];
   assign tx_room  = ~flags_s[1];

   // ---------------- bus decode ----------------
   logic                any_rd;
   logic                io_rd;
   logic                rd_start;
   logic                wr_start;
   logic                ack_start;
   logic                mem_wr;
   logic                win_hit;
   logic [WIN_BITS-1:0] offset;

   acia_bus_decode #(
      .ADDR_W    (ADDR_W),
      .WIN_BITS  (WIN_BITS),
      .WIN_A     (WIN_A),
      .WIN_B     (WIN_B),
      .MIRROR_EN (MIRROR_EN)
   ) i_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (cpu_addr),
      .iord_n    (cpu_iord_n),
      .iowr_n    (cpu_iowr_n),
      .mreq_n    (cpu_mreq_n),
      .rd_n      (cpu_rd_n),
      .wr_n      (cpu_wr_n),
      .m1_n      (cpu_m1_n),
      .any_rd    (any_rd),
      .io_rd     (io_rd),
      .rd_start  (rd_start),
      .wr_start  (wr_start),
      .ack_start (ack_start),
      .mem_wr    (mem_wr),
      .win_hit   (win_hit),
      .offset    (offset)
   );

   // ---------------- write side and mode flag ----------------
   logic boot;

   acia_wr_ctl #(
      .DATA_W   (DATA_W),
      .WIN_BITS (WIN_BITS)
   ) i_wr_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_start  (wr_start),
      .rd_start  (rd_start),
      .io_rd     (io_rd),
      .ack_start (ack_start),
      .win_hit   (win_hit),
      .offset    (offset),
      .din       (cpu_din),
      .fifo_wr_n (fifo_wr_n),
      .fifo_dout (fifo_dout),
      .page_we   (page_we),
      .page_data (page_data),
      .boot      (boot)
   );

   // ---------------- read side ----------------
   logic              need_fifo;
   logic              rd_busy;
   logic              rd_hold;
   logic [DATA_W-1:0] rd_byte;

   assign need_fifo = boot || (io_rd && win_hit && (offset == WIN_BITS'(OFS_DATA)));

   acia_rd_engine #(
      .DATA_W (DATA_W)
   ) i_rd_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_start  (rd_start),
      .any_rd    (any_rd),
      .need_fifo (need_fifo),
      .rx_avail  (rx_avail),
      .fifo_din  (fifo_din),
      .busy      (rd_busy),
      .hold      (rd_hold),
      .byte_q    (rd_byte),
      .fifo_rd_n (fifo_rd_n),
      .wait_n    (cpu_wait_n)
   );

   // ---------------- return path ----------------
   logic              status_rd;
   logic [DATA_W-1:0] status_byte;

   assign status_rd = io_rd && win_hit && !boot && !rd_busy &&
                      (offset == WIN_BITS'(OFS_STATUS));

   always_comb begin
      status_byte              = '0;
      status_byte[ST_RX_READY] = rx_avail;
      status_byte[ST_TX_EMPTY] = tx_room;
   end

   always_comb begin
      if (rd_hold) begin
         cpu_dout = rd_byte;
      end else if (status_rd) begin
         cpu_dout = status_byte;
      end else begin
         cpu_dout = '0;
      end
   end

   assign cpu_dout_oe = rd_hold || status_rd;

   // R2
   status_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_dout_oe && !rd_hold) |-> (cpu_dout[DATA_W-1:2] == PAD_W'(0)));

   // R8
   tx_from_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_wr_n |-> $past(!cpu_iowr_n && !mem_wr));

   // R4
   wait_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_wait_n |-> any_rd);

endmodule

// File: tb/test_fifo_acia_bridge.sv
`timescale 1ns/1ps
module test_fifo_acia_bridge;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] cpu_addr;
   logic [7:0] cpu_din;
   logic       cpu_iord_n, cpu_iowr_n, cpu_mreq_n, cpu_rd_n, cpu_wr_n, cpu_m1_n;
   logic [7:0] cpu_dout;
   logic       cpu_dout_oe, cpu_wait_n;
   logic [7:0] fifo_din;
   logic       fifo_rxf_n, fifo_txe_n;
   logic       fifo_rd_n, fifo_wr_n;
   logic [7:0] fifo_dout;
   logic       page_we;
   logic [7:0] page_data;

   always #2 clk = ~clk;

   fifo_acia_bridge i_fifo_acia_bridge (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
      .cpu_iord_n(cpu_iord_n), .cpu_iowr_n(cpu_iowr_n), .cpu_mreq_n(cpu_mreq_n),
      .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_m1_n(cpu_m1_n),
      .cpu_dout(cpu_dout), .cpu_dout_oe(cpu_dout_oe), .cpu_wait_n(cpu_wait_n),
      .fifo_din(fifo_din), .fifo_rxf_n(fifo_rxf_n), .fifo_txe_n(fifo_txe_n),
      .fifo_rd_n(fifo_rd_n), .fifo_wr_n(fifo_wr_n), .fifo_dout(fifo_dout),
      .page_we(page_we), .page_data(page_data)
   );

   int vectors = 0;
   int miscompares = 0;

   logic [7:0] rxq[$];
   logic [7:0] txlog[$];
   bit         pend_pop;
   int         rd_pulses;
   int         pg_count;
   logic [7:0] pg_last;

   // behavioural reference state
   bit         m_boot, m_rdq, m_wrq, m_ackq;
   int         m_phase;   // 0 idle, 1 stalled, 2 fetching, 3 holding
   logic [7:0] m_byte;
   bit         m_txp, m_pgp;
   logic [7:0] m_txd, m_pgd;

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic fifo_refresh();
      fifo_rxf_n = (rxq.size() == 0);
      fifo_din   = (rxq.size() != 0) ? rxq[0] : 8'h00;
   endtask

   task automatic model_and_compare();
      bit io_rd, any_rd, hit, rdst, wrst, ackst, ack, need, st_rd;
      int off;
      bit exp_wait, exp_rdn, exp_oe;
      logic [7:0] exp_d;
      io_rd  = !cpu_iord_n && cpu_m1_n;
      any_rd = (!cpu_mreq_n && !cpu_rd_n) || io_rd;
      ack    = !cpu_iord_n && !cpu_m1_n;
      hit    = (cpu_addr[7:3] == 5'h10) || (cpu_addr[7:3] == 5'h14);
      off    = int'(cpu_addr[2:0]);
      if (!rst_n) begin
         m_boot = 1; m_rdq = 0; m_wrq = 0; m_ackq = 0; m_phase = 0;
         m_byte = 0; m_txp = 0; m_pgp = 0;
      end else begin
         rdst  = any_rd && !m_rdq;
         wrst  = !cpu_iowr_n && !m_wrq;
         ackst = ack && !m_ackq;
         need  = m_boot || (io_rd && hit && off == 1);
         case (m_phase)
            0: if (rdst && need) m_phase = (fifo_rxf_n == 0) ? 2 : 1;
            1: if (!any_rd) m_phase = 0; else if (fifo_rxf_n == 0) m_phase = 2;
            2: begin m_byte = fifo_din; m_phase = 3; end
            default: if (!any_rd) m_phase = 0;
         endcase
         m_txp = wrst && hit && off == 1;
         if (m_txp) m_txd = cpu_din;
         m_pgp = wrst && hit && off == 2;
         if (m_pgp) m_pgd = cpu_din;
         if ((rdst && io_rd && hit && off == 3) || (wrst && hit && off == 3) || ackst)
            m_boot = 0;
         m_rdq = any_rd; m_wrq = !cpu_iowr_n; m_ackq = ack;
      end
      exp_wait = !(m_phase == 1 || m_phase == 2);
      exp_rdn  = !(m_phase == 2);
      st_rd    = io_rd && hit && off == 0 && !m_boot && m_phase == 0 && rst_n;
      exp_oe   = (m_phase == 3) || st_rd;
      exp_d    = (m_phase == 3) ? m_byte : {6'b0, !fifo_txe_n, !fifo_rxf_n};
      check("R4", "cpu_wait_n", {7'b0, cpu_wait_n}, {7'b0, exp_wait});
      check("R11", "fifo_rd_n", {7'b0, fifo_rd_n}, {7'b0, exp_rdn});
      check("R5", "fifo_wr_n", {7'b0, fifo_wr_n}, {7'b0, !m_txp});
      if (m_txp) check("R5", "fifo_dout", fifo_dout, m_txd);
      check("R10", "page_we", {7'b0, page_we}, {7'b0, m_pgp});
      if (m_pgp) check("R10", "page_data", page_data, m_pgd);
      check("R3", "cpu_dout_oe", {7'b0, cpu_dout_oe}, {7'b0, exp_oe});
      if (exp_oe) check("R3", "cpu_dout", cpu_dout, exp_d);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      model_and_compare();
      if (pend_pop) begin
         void'(rxq.pop_front());
         fifo_refresh();
      end
      pend_pop = (fifo_rd_n === 1'b0) && rst_n;
      if (fifo_rd_n === 1'b0) rd_pulses++;
      if (fifo_wr_n === 1'b0) txlog.push_back(fifo_dout);
      if (page_we === 1'b1) begin pg_count++; pg_last = page_data; end
   endtask

   task automatic bus_idle();
      cpu_iord_n = 1; cpu_iowr_n = 1; cpu_mreq_n = 1;
      cpu_rd_n = 1; cpu_wr_n = 1; cpu_m1_n = 1;
   endtask

   task automatic do_reset();
      rst_n = 0;
      bus_idle();
      rxq.delete();
      fifo_refresh();
      pend_pop = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
   endtask

   // kind: 0 I/O read, 1 memory read, 2 opcode fetch
   task automatic do_read(input int kind, input logic [7:0] a, input int feed_at,
                          input logic [7:0] feed_b, input int extra,
                          output logic [7:0] d, output bit got, output int waits);
      cpu_addr = a;
      if (kind == 0) cpu_iord_n = 0;
      else begin
         cpu_mreq_n = 0; cpu_rd_n = 0;
         if (kind == 2) cpu_m1_n = 0;
      end
      got = 0; waits = 0; d = 8'h00;
      for (int i = 0; i < 30 && !got; i++) begin
         tick();
         if (cpu_wait_n === 1'b0) waits++;
         if (cpu_dout_oe === 1'b1) begin got = 1; d = cpu_dout; end
         if (i == feed_at) begin rxq.push_back(feed_b); fifo_refresh(); end
      end
      repeat (extra) tick();
      bus_idle();
      tick(); tick();
   endtask

   task automatic io_write(input logic [7:0] a, input logic [7:0] d, output int waits);
      cpu_addr = a; cpu_din = d; cpu_iowr_n = 0; waits = 0;
      for (int i = 0; i < 3; i++) begin
         tick();
         if (cpu_wait_n === 1'b0) waits++;
      end
      bus_idle();
      tick(); tick();
   endtask

   task automatic mem_write(input logic [7:0] a, input logic [7:0] d);
      cpu_addr = a; cpu_din = d; cpu_mreq_n = 0; cpu_wr_n = 0;
      repeat (3) tick();
      bus_idle();
      tick(); tick();
   endtask

   task automatic int_ack();
      cpu_m1_n = 0; cpu_iord_n = 0;
      repeat (3) tick();
      bus_idle();
      tick(); tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL R11 watchdog: actual still running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [7:0] d;
      bit got;
      int w, n0, p0;
      cpu_addr = 0; cpu_din = 0; fifo_txe_n = 0; pg_last = 0;
      rd_pulses = 0; pg_count = 0;
      do_reset();
      check("R7", "reset wait", {7'b0, cpu_wait_n}, 8'h01);
      check("R7", "reset oe", {7'b0, cpu_dout_oe}, 8'h00);

      // bootstrap stream: every read comes from the FIFO in order
      rxq = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5};
      fifo_refresh();
      do_read(1, 8'h00, -1, 0, 0, d, got, w);
      check("R7", "boot mem read", d, 8'hA1);
      do_read(2, 8'h40, -1, 0, 0, d, got, w);
      check("R7", "boot opcode fetch", d, 8'hB2);
      do_read(0, 8'h80, -1, 0, 0, d, got, w);
      check("R7", "boot read of status port", d, 8'hC3);
      do_read(0, 8'h10, -1, 0, 0, d, got, w);
      check("R7", "boot read outside window", d, 8'hD4);

      n0 = txlog.size();
      mem_write(8'h81, 8'h99);
      check("R8", "boot mem write not sent", 8'(txlog.size()), 8'(n0));
      io_write(8'h81, 8'h5A, w);
      check("R8", "boot io write sent", 8'(txlog.size()), 8'(n0 + 1));
      check("R8", "boot io write byte", txlog[$], 8'h5A);

      do_read(0, 8'h83, -1, 0, 0, d, got, w);
      check("R9", "exit read served from FIFO", d, 8'hE5);
      rxq.push_back(8'h77); fifo_refresh();
      do_read(1, 8'h00, -1, 0, 0, d, got, w);
      check("R9", "mem read after exit not served", {7'b0, got}, 8'h00);
      check("R9", "FIFO untouched after exit", 8'(rxq.size()), 8'd1);

      // normal mode
      fifo_txe_n = 0;
      do_read(0, 8'h80, -1, 0, 0, d, got, w);
      check("R2", "status rx+tx", d, 8'h03);
      fifo_txe_n = 1;
      do_read(0, 8'h80, -1, 0, 0, d, got, w);
      check("R2", "status rx only", d, 8'h01);
      do_read(0, 8'hA0, -1, 0, 0, d, got, w);
      check("R1", "mirror status", d, 8'h01);

      p0 = rd_pulses;
      do_read(0, 8'h81, -1, 0, 6, d, got, w);
      check("R3", "data read byte", d, 8'h77);
      check("R11", "one strobe per long read", 8'(rd_pulses - p0), 8'd1);
      do_read(0, 8'h80, -1, 0, 0, d, got, w);
      check("R2", "status empty full", d, 8'h00);

      do_read(0, 8'h89, -1, 0, 0, d, got, w);
      check("R1", "0x89 not decoded", {7'b0, got}, 8'h00);
      check("R1", "0x89 no wait", 8'(w), 8'd0);
      do_read(0, 8'hB1, -1, 0, 0, d, got, w);
      check("R1", "0xB1 not decoded", {7'b0, got}, 8'h00);
      do_read(0, 8'h84, -1, 0, 0, d, got, w);
      check("R6", "offset 4 read undriven", {7'b0, got}, 8'h00);
      do_read(0, 8'h82, -1, 0, 0, d, got, w);
      check("R6", "page port read undriven", {7'b0, got}, 8'h00);

      p0 = rd_pulses;
      do_read(0, 8'hA1, 5, 8'h9C, 0, d, got, w);
      check("R4", "stalled read byte", d, 8'h9C);
      check("R4", "stall long enough", {7'b0, w >= 6}, 8'h01);
      check("R11", "one strobe after stall", 8'(rd_pulses - p0), 8'd1);

      n0 = txlog.size(); p0 = pg_count;
      io_write(8'h80, 8'hFF, w);
      io_write(8'h85, 8'h11, w);
      io_write(8'hA7, 8'h12, w);
      check("R6", "control writes ignored tx", 8'(txlog.size()), 8'(n0));
      check("R6", "control writes ignored page", 8'(pg_count), 8'(p0));

      io_write(8'h82, 8'h3C, w);
      check("R10", "page count", 8'(pg_count), 8'(p0 + 1));
      check("R10", "page value", pg_last, 8'h3C);
      io_write(8'hA2, 8'h0F, w);
      check("R10", "mirror page value", pg_last, 8'h0F);

      fifo_txe_n = 1;
      io_write(8'hA1, 8'h66, w);
      check("R5", "write never waits", 8'(w), 8'd0);
      check("R5", "write byte sent", txlog[$], 8'h66);
      check("R5", "write count", 8'(txlog.size()), 8'(n0 + 1));

      // interrupt acknowledge clears bootstrap
      do_reset();
      rxq.push_back(8'h42); fifo_refresh();
      int_ack();
      do_read(1, 8'h00, -1, 0, 0, d, got, w);
      check("R9", "mem read after ack not served", {7'b0, got}, 8'h00);
      check("R9", "FIFO kept after ack", 8'(rxq.size()), 8'd1);

      // write to mirrored exit port clears bootstrap
      do_reset();
      rxq.push_back(8'h24); fifo_refresh();
      io_write(8'hA3, 8'h00, w);
      do_read(2, 8'h00, -1, 0, 0, d, got, w);
      check("R9", "fetch after exit write not served", {7'b0, got}, 8'h00);
      check("R9", "FIFO kept after exit write", 8'(rxq.size()), 8'd1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule